// File: doc/BRIEF.md
# Nibble-Serial Instruction Decoder with Static Jump Prediction

This block sits between instruction fetch and the back end. Fetch hands it whole 64-byte line bundles, each tagged with a generation number, its line address and the line fetch intends to deliver next. The decoder walks the bytes at its program counter and builds variable-length instructions. Every byte picks one of four 64-bit fields, can invert that field, and then shifts a 4-bit nibble into it. Up to four bytes are taken per cycle and at most one instruction is finished per cycle.

A finished instruction goes out with the downstream generation, its linear next PC and a predicted next PC. Absolute conditional jumps are predicted statically. A jump with a known target and a known condition follows that condition. A jump whose target is known but whose condition is not is taken only when it points backward. A jump whose target is unknown, and which may be taken, goes out with no prediction, and decoding then stalls until the back end restarts it.

A restart from the back end reloads the PC and the downstream generation and asks fetch to restart. The decoder also asks fetch to restart when the current-generation line stream has drifted away from the PC. Bundles that are stale or that belong to another line are dropped.

Top module: `nsd_decoder`

## Requirements
- R1: A unit byte is laid out as hold = bit 7, invert = bit 6, field select = bits 5:4, nibble = bits 3:0. Each consumed byte first inverts the selected 64-bit field if invert is set. It then shifts the field left by 4 and places the nibble in bits 3:0. The PC and the instruction size each advance by one.
- R2: At most four bytes are consumed per clock. Consumption stops for the rest of the cycle once a byte with hold clear has finished an instruction, so at most one instruction leaves per cycle.
- R3: A byte is consumed only when all of these hold: the bundle generation equals the upstream generation, the bundle line equals PC[31:6], and the output slot is empty or being accepted. While the output is valid and not ready, it holds its contents and nothing is consumed.
- R4: A finished instruction is presented on the clock after its last byte. It carries the downstream generation and a linear next PC equal to the PC after its last byte. The next instruction starts from all-zero fields. After reset the output and the fetch request are idle.
- R5: The jump-if-zero opcode is field 0 = 1 and jump-if-nonzero is field 0 = 2. Field 1 bit 0 marks the target (field 2) as known, and field 1 bit 1 marks the condition on field 3 as known. With both known, the predicted next PC, and the PC, become the target when the condition holds, and the linear next PC otherwise.
- R6: With the target known and the condition unknown, the jump is predicted taken only when the target is below the linear next PC.
- R7: A jump with an unknown target whose condition is unknown or true is emitted with the prediction-valid flag low. The size is then forced to 64, the limit at which decoding stalls. While stalled, no byte is consumed and no bundle is popped until a restart.
- R8: A restart loads the PC and the downstream generation and clears the partial instruction. It increments the upstream generation. On the next clock it raises a one-cycle fetch request carrying the new upstream generation, the line of the new PC and the supplied source line.
- R9: After a cycle's bytes are applied, a current-generation bundle whose line is neither the PC's line nor its next-line hint raises a fetch request on the next clock. The request carries an incremented upstream generation, the PC's line and the bundle's line as its source.
- R10: A bundle is popped in the cycle it is presented when its generation is stale or its line differs from the PC's line after that cycle's bytes. A bundle whose line matches is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rs_valid_i | input | 1 | Back-end restart strobe |
| rs_gen_i | input | 4 | New downstream generation |
| rs_pc_i | input | 32 | New PC |
| rs_from_line_i | input | 26 | Line address the redirect came from |
| bnd_valid_i | input | 1 | Bundle present |
| bnd_gen_i | input | 4 | Bundle generation |
| bnd_line_i | input | 26 | Bundle line address |
| bnd_next_line_i | input | 26 | Line fetch will send next |
| bnd_data_i | input | 512 | Line bytes, byte k in bits 8k+7:8k |
| bnd_pop_o | output | 1 | Bundle is dropped this cycle |
| inst_valid_o | output | 1 | Instruction valid |
| inst_ready_i | input | 1 | Downstream accepts the instruction |
| inst_gen_o | output | 4 | Downstream generation tag |
| inst_fields_o | output | 256 | Fields, field k in bits 64k+63:64k |
| inst_lin_pc_o | output | 32 | Linear next PC |
| inst_pred_ok_o | output | 1 | Predicted next PC is valid |
| inst_pred_pc_o | output | 32 | Predicted next PC |
| fr_valid_o | output | 1 | Fetch restart request |
| fr_gen_o | output | 4 | Upstream generation for fetch |
| fr_line_o | output | 26 | Line fetch should restart at |
| fr_prev_line_o | output | 26 | Source line of the redirect |

## Verification
The checks assume that a bundle presented with the current generation and the PC's line really holds the bytes for those addresses. They also assume that inst_ready may fall only while an instruction is valid, and that a restart and a bundle never need to be taken in the same cycle. The stimulus drives one bundle at a time at the PC's own line, with offsets chosen so that no instruction crosses a line. Restarts come only while no bundle is valid. Back-pressure is applied only after an instruction is already being presented.

// File: rtl/nsd_pkg.sv
package nsd_pkg;
    localparam int FIELD_W    = 64;
    localparam int FIELD_CNT  = 4;
    localparam int FIELD_IW   = $clog2(FIELD_CNT);
    localparam int LINE_LOG2  = 6;
    localparam int LINE_BYTES = 1 << LINE_LOG2;

    localparam int FLD_OPC   = 0;
    localparam int FLD_FLAGS = 1;
    localparam int FLD_TGT   = 2;
    localparam int FLD_COND  = 3;

    localparam logic [FIELD_W-1:0] OPC_JZ  = 64'd1;
    localparam logic [FIELD_W-1:0] OPC_JNZ = 64'd2;
    localparam int FLAG_TGT_BIT  = 0;
    localparam int FLAG_COND_BIT = 1;

    typedef logic [FIELD_CNT-1:0][FIELD_W-1:0] fields_t;

    typedef struct packed {
        logic                hold;
        logic                inv;
        logic [FIELD_IW-1:0] sel;
        logic [3:0]          nib;
    } ubyte_t;
endpackage

// File: rtl/nsd_lane.sv
module nsd_lane
    import nsd_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int SIZE_W   = 7,
    parameter int MAX_SIZE = 64
) (
    input  logic                         en_i,
    input  logic [PC_W-LINE_LOG2-1:0]    bnd_line_i,
    input  logic [LINE_BYTES*8-1:0]      line_data_i,
    input  logic [PC_W-1:0]              pc_i,
    input  logic [SIZE_W-1:0]            size_i,
    input  fields_t                      fields_i,
    input  logic                         done_i,
    output logic [PC_W-1:0]              pc_o,
    output logic [SIZE_W-1:0]            size_o,
    output fields_t                      fields_o,
    output logic                         done_o
);
    logic [LINE_LOG2-1:0] off;
    ubyte_t               ub;
    logic                 take;
    logic [FIELD_W-1:0]   cur;

    always_comb begin
        off  = pc_i[LINE_LOG2-1:0];
        ub   = ubyte_t'(line_data_i[{off, 3'b000} +: 8]);
        take = en_i && !done_i && (size_i < SIZE_W'(MAX_SIZE))
               && (pc_i[PC_W-1:LINE_LOG2] == bnd_line_i);
        pc_o     = pc_i;
        size_o   = size_i;
        fields_o = fields_i;
        done_o   = done_i;
        cur      = fields_i[ub.sel];
        if (ub.inv) begin
            cur = ~cur;
        end
        if (take) begin
            fields_o[ub.sel] = {cur[FIELD_W-5:0], ub.nib};
            pc_o             = pc_i + PC_W'(1);
            size_o           = size_i + SIZE_W'(1);
            done_o           = !ub.hold;
        end
    end
endmodule

// File: rtl/nsd_jump_pred.sv
module nsd_jump_pred
    import nsd_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [FIELD_W-1:0] opc_i,
    input  logic [1:0]         flags_i,
    input  logic [PC_W-1:0]    target_i,
    input  logic [FIELD_W-1:0] cond_i,
    input  logic [PC_W-1:0]    lin_pc_i,
    output logic               redirect_o,
    output logic               unpred_o
);
    logic is_jz, is_jump, tgt_known, cond_known, cond_true;

    always_comb begin
        is_jz      = (opc_i == OPC_JZ);
        is_jump    = is_jz || (opc_i == OPC_JNZ);
        tgt_known  = flags_i[FLAG_TGT_BIT];
        cond_known = flags_i[FLAG_COND_BIT];
        cond_true  = is_jz ? (cond_i == '0) : (cond_i != '0);
        redirect_o = is_jump && tgt_known
                     && (cond_known ? cond_true : (target_i < lin_pc_i));
        unpred_o   = is_jump && !tgt_known && (!cond_known || cond_true);
    end
endmodule

// File: rtl/nsd_decoder.sv
module nsd_decoder
    import nsd_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int GEN_W    = 4,
    parameter int LANES    = 4,
    parameter int MAX_SIZE = 64
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           rs_valid_i,
    input  logic [GEN_W-1:0]               rs_gen_i,
    input  logic [PC_W-1:0]                rs_pc_i,
    input  logic [PC_W-LINE_LOG2-1:0]      rs_from_line_i,
    input  logic                           bnd_valid_i,
    input  logic [GEN_W-1:0]               bnd_gen_i,
    input  logic [PC_W-LINE_LOG2-1:0]      bnd_line_i,
    input  logic [PC_W-LINE_LOG2-1:0]      bnd_next_line_i,
    input  logic [LINE_BYTES*8-1:0]        bnd_data_i,
    output logic                           bnd_pop_o,
    output logic                           inst_valid_o,
    input  logic                           inst_ready_i,
    output logic [GEN_W-1:0]               inst_gen_o,
    output logic [FIELD_CNT*FIELD_W-1:0]   inst_fields_o,
    output logic [PC_W-1:0]                inst_lin_pc_o,
    output logic                           inst_pred_ok_o,
    output logic [PC_W-1:0]                inst_pred_pc_o,
    output logic                           fr_valid_o,
    output logic [GEN_W-1:0]               fr_gen_o,
    output logic [PC_W-LINE_LOG2-1:0]      fr_line_o,
    output logic [PC_W-LINE_LOG2-1:0]      fr_prev_line_o
);
    localparam int SIZE_W = $clog2(MAX_SIZE + 1);
    localparam int LA_W   = PC_W - LINE_LOG2;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [SIZE_W-1:0] size;
        fields_t           fields;
        logic [GEN_W-1:0]  gen_up;
        logic [GEN_W-1:0]  gen_dn;
        logic              o_valid;
        logic [GEN_W-1:0]  o_gen;
        fields_t           o_fields;
        logic [PC_W-1:0]   o_lin;
        logic              o_ok;
        logic [PC_W-1:0]   o_pred;
        logic              f_valid;
        logic [GEN_W-1:0]  f_gen;
        logic [LA_W-1:0]   f_line;
        logic [LA_W-1:0]   f_prev;
    } state_t;

    state_t q, d;

    logic [PC_W-1:0]   pc_c   [LANES+1];
    logic [SIZE_W-1:0] size_c [LANES+1];
    fields_t           fld_c  [LANES+1];
    logic              done_c [LANES+1];

    logic            can_wr, gen_ok, stalled, lane_en;
    logic            redirect, unpred;
    logic [LA_W-1:0] line_now;
    logic [PC_W-1:0] tgt;

    assign can_wr  = !q.o_valid || inst_ready_i;
    assign gen_ok  = (bnd_gen_i == q.gen_up);
    assign stalled = (q.size >= SIZE_W'(MAX_SIZE));
    assign lane_en = bnd_valid_i && !rs_valid_i && gen_ok && can_wr;

    assign pc_c[0]   = q.pc;
    assign size_c[0] = q.size;
    assign fld_c[0]  = q.fields;
    assign done_c[0] = 1'b0;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        nsd_lane #(
            .PC_W    (PC_W),
            .SIZE_W  (SIZE_W),
            .MAX_SIZE(MAX_SIZE)
        ) lane_i (
            .en_i       (lane_en),
            .bnd_line_i (bnd_line_i),
            .line_data_i(bnd_data_i),
            .pc_i       (pc_c[l]),
            .size_i     (size_c[l]),
            .fields_i   (fld_c[l]),
            .done_i     (done_c[l]),
            .pc_o       (pc_c[l+1]),
            .size_o     (size_c[l+1]),
            .fields_o   (fld_c[l+1]),
            .done_o     (done_c[l+1])
        );
    end

    assign tgt = fld_c[LANES][FLD_TGT][PC_W-1:0];

    nsd_jump_pred #(.PC_W(PC_W)) pred_i (
        .opc_i     (fld_c[LANES][FLD_OPC]),
        .flags_i   (fld_c[LANES][FLD_FLAGS][1:0]),
        .target_i  (tgt),
        .cond_i    (fld_c[LANES][FLD_COND]),
        .lin_pc_i  (pc_c[LANES]),
        .redirect_o(redirect),
        .unpred_o  (unpred)
    );

    always_comb begin
        d         = q;
        d.f_valid = 1'b0;
        bnd_pop_o = 1'b0;
        line_now  = q.pc[PC_W-1:LINE_LOG2];
        if (q.o_valid && inst_ready_i) begin
            d.o_valid = 1'b0;
        end
        if (rs_valid_i) begin
            d.gen_dn  = rs_gen_i;
            d.pc      = rs_pc_i;
            d.size    = '0;
            d.fields  = '0;
            d.gen_up  = q.gen_up + GEN_W'(1);
            d.f_valid = 1'b1;
            d.f_gen   = q.gen_up + GEN_W'(1);
            d.f_line  = rs_pc_i[PC_W-1:LINE_LOG2];
            d.f_prev  = rs_from_line_i;
        end else if (!stalled && bnd_valid_i) begin
            d.pc     = pc_c[LANES];
            d.size   = size_c[LANES];
            d.fields = fld_c[LANES];
            if (done_c[LANES]) begin
                d.o_valid  = 1'b1;
                d.o_gen    = q.gen_dn;
                d.o_fields = fld_c[LANES];
                d.o_lin    = pc_c[LANES];
                d.o_ok     = !unpred;
                d.o_pred   = redirect ? tgt : pc_c[LANES];
                d.pc       = redirect ? tgt : pc_c[LANES];
                d.size     = unpred ? SIZE_W'(MAX_SIZE) : '0;
                d.fields   = '0;
            end
            line_now = d.pc[PC_W-1:LINE_LOG2];
            if (gen_ok && (bnd_line_i != line_now) && (bnd_next_line_i != line_now)) begin
                d.gen_up  = q.gen_up + GEN_W'(1);
                d.f_valid = 1'b1;
                d.f_gen   = q.gen_up + GEN_W'(1);
                d.f_line  = line_now;
                d.f_prev  = bnd_line_i;
            end
            bnd_pop_o = !gen_ok || (bnd_line_i != line_now);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign inst_valid_o   = q.o_valid;
    assign inst_gen_o     = q.o_gen;
    assign inst_fields_o  = q.o_fields;
    assign inst_lin_pc_o  = q.o_lin;
    assign inst_pred_ok_o = q.o_ok;
    assign inst_pred_pc_o = q.o_pred;
    assign fr_valid_o     = q.f_valid;
    assign fr_gen_o       = q.f_gen;
    assign fr_line_o      = q.f_line;
    assign fr_prev_line_o = q.f_prev;
endmodule

// File: rtl/nsd_decoder_chk.sv
module nsd_decoder_chk #(
    parameter int PC_W     = 32,
    parameter int GEN_W    = 4,
    parameter int SIZE_W   = 7,
    parameter int MAX_SIZE = 64,
    parameter int FLD_ALL  = 256
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               rs_valid_i,
    input logic               bnd_valid_i,
    input logic [GEN_W-1:0]   bnd_gen_i,
    input logic               bnd_pop_o,
    input logic               inst_valid_o,
    input logic               inst_ready_i,
    input logic [PC_W-1:0]    inst_lin_pc_o,
    input logic [FLD_ALL-1:0] inst_fields_o,
    input logic               fr_valid_o,
    input logic [GEN_W-1:0]   fr_gen_o,
    input logic [GEN_W-1:0]   gen_up_i,
    input logic [SIZE_W-1:0]  size_i
);
    // R3: a presented instruction is frozen while the consumer refuses it
    a_r3_hold_under_backpressure: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inst_valid_o && !inst_ready_i |=> inst_valid_o && $stable(inst_lin_pc_o) && $stable(inst_fields_o));

    // R8: every back-end restart turns into a fetch request with the next generation
    a_r8_restart_requests_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rs_valid_i |=> fr_valid_o && (fr_gen_o == $past(gen_up_i) + GEN_W'(1)));

    // R7: while stalled at the size limit no bundle is dropped
    a_r7_stall_keeps_bundle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (size_i >= SIZE_W'(MAX_SIZE)) && !rs_valid_i |-> !bnd_pop_o);

    // R7: the stall lasts until a restart arrives
    a_r7_stall_persists: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (size_i >= SIZE_W'(MAX_SIZE)) && !rs_valid_i |=> (size_i >= SIZE_W'(MAX_SIZE)));

    // R9: a fetch request has a restart or a bundle behind it
    a_r9_fetch_request_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fr_valid_o |-> $past(rs_valid_i) || $past(bnd_valid_i));

    // R10: a stale bundle is always dropped when the decoder looks at it
    a_r10_stale_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bnd_valid_i && !rs_valid_i && (size_i < SIZE_W'(MAX_SIZE)) && (bnd_gen_i != gen_up_i) |-> bnd_pop_o);
endmodule

bind nsd_decoder nsd_decoder_chk #(
    .PC_W    (PC_W),
    .GEN_W   (GEN_W),
    .SIZE_W  (SIZE_W),
    .MAX_SIZE(MAX_SIZE),
    .FLD_ALL (nsd_pkg::FIELD_CNT * nsd_pkg::FIELD_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rs_valid_i   (rs_valid_i),
    .bnd_valid_i  (bnd_valid_i),
    .bnd_gen_i    (bnd_gen_i),
    .bnd_pop_o    (bnd_pop_o),
    .inst_valid_o (inst_valid_o),
    .inst_ready_i (inst_ready_i),
    .inst_lin_pc_o(inst_lin_pc_o),
    .inst_fields_o(inst_fields_o),
    .fr_valid_o   (fr_valid_o),
    .fr_gen_o     (fr_gen_o),
    .gen_up_i     (q.gen_up),
    .size_i       (q.size)
);

// File: tb/nsd_decoder_tb_top.sv
module nsd_decoder_tb_top;
    import nsd_pkg::*;
    localparam int PC_W   = 32;
    localparam int GEN_W  = 4;
    localparam int LA_W   = PC_W - LINE_LOG2;
    localparam int DATA_W = LINE_BYTES * 8;

    typedef struct packed {
        logic [31:0] start;
        logic [63:0] bytes;
        logic [63:0] opc;
        logic [31:0] lin;
        logic        ok;
        logic [31:0] pred;
        logic        div;
    } vec_t;

    // bytes: unit 0 in bits 7:0; layout hold=7 inv=6 sel=5:4 nib=3:0
    localparam vec_t VEC [8] = '{
        '{32'h40, 64'h0583,           64'h35,                  32'h42, 1'b1, 32'h42, 1'b0}, // R1 plain
        '{32'h80, 64'h01C08F,         64'hFFFF_FFFF_FFFF_F001, 32'h83, 1'b1, 32'h83, 1'b0}, // R1 invert
        '{32'h40, 64'h30A8ACA09381,   64'h1,                   32'h46, 1'b1, 32'hC8, 1'b1}, // R5 jz taken
        '{32'h40, 64'h30A8ACA09382,   64'h2,                   32'h46, 1'b1, 32'h46, 1'b0}, // R5 jnz not taken
        '{32'h80, 64'h30A0A4A09181,   64'h1,                   32'h86, 1'b1, 32'h40, 1'b1}, // R6 backward
        '{32'h80, 64'h30A0AFA09181,   64'h1,                   32'h86, 1'b1, 32'h86, 1'b0}, // R6 forward
        '{32'h40, 64'h359281,         64'h1,                   32'h43, 1'b1, 32'h43, 1'b0}, // R5 cond false
        '{32'h40, 64'h1081,           64'h1,                   32'h42, 1'b0, 32'h0,  1'b0}  // R7 unknown target
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                 rst_n;
    logic                 rs_valid;
    logic [GEN_W-1:0]     rs_gen;
    logic [PC_W-1:0]      rs_pc;
    logic [LA_W-1:0]      rs_from_line;
    logic                 bnd_valid;
    logic [GEN_W-1:0]     bnd_gen;
    logic [LA_W-1:0]      bnd_line, bnd_next;
    logic [DATA_W-1:0]    bnd_data;
    logic                 bnd_pop;
    logic                 inst_valid, inst_ready;
    logic [GEN_W-1:0]     inst_gen;
    logic [FIELD_CNT*FIELD_W-1:0] inst_fields;
    logic [PC_W-1:0]      inst_lin, inst_pred;
    logic                 inst_ok;
    logic                 fr_valid;
    logic [GEN_W-1:0]     fr_gen;
    logic [LA_W-1:0]      fr_line, fr_prev;

    nsd_decoder dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .rs_valid_i(rs_valid), .rs_gen_i(rs_gen), .rs_pc_i(rs_pc), .rs_from_line_i(rs_from_line),
        .bnd_valid_i(bnd_valid), .bnd_gen_i(bnd_gen), .bnd_line_i(bnd_line),
        .bnd_next_line_i(bnd_next), .bnd_data_i(bnd_data), .bnd_pop_o(bnd_pop),
        .inst_valid_o(inst_valid), .inst_ready_i(inst_ready), .inst_gen_o(inst_gen),
        .inst_fields_o(inst_fields), .inst_lin_pc_o(inst_lin), .inst_pred_ok_o(inst_ok),
        .inst_pred_pc_o(inst_pred), .fr_valid_o(fr_valid), .fr_gen_o(fr_gen),
        .fr_line_o(fr_line), .fr_prev_line_o(fr_prev)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [GEN_W-1:0] exp_up = '0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_restart(input logic [31:0] pc, input logic [GEN_W-1:0] g);
        @(negedge clk);
        rs_valid = 1'b1; rs_pc = pc; rs_gen = g; rs_from_line = pc[PC_W-1:LINE_LOG2];
        @(negedge clk);
        rs_valid = 1'b0;
        exp_up++;
        chk("R8 restart fetch valid", 64'(fr_valid), 64'd1);
        chk("R8 restart fetch gen", 64'(fr_gen), 64'(exp_up));
        chk("R8 restart fetch line", 64'(fr_line), 64'(pc[PC_W-1:LINE_LOG2]));
        chk("R8 restart source line", 64'(fr_prev), 64'(pc[PC_W-1:LINE_LOG2]));
    endtask

    task automatic put_bundle(input logic [GEN_W-1:0] g, input logic [LA_W-1:0] line,
                              input logic [LA_W-1:0] nxt, input logic [5:0] off,
                              input logic [63:0] bytes);
        bnd_data = '0;
        for (int k = 0; k < 8; k++) begin
            bnd_data[(int'(off) + k) * 8 +: 8] = bytes[k*8 +: 8];
        end
        bnd_gen = g; bnd_line = line; bnd_next = nxt; bnd_valid = 1'b1;
    endtask

    task automatic wait_inst();
        for (int c = 0; c < 6 && !inst_valid; c++) begin
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rs_valid = 1'b0; rs_gen = '0; rs_pc = '0; rs_from_line = '0;
        bnd_valid = 1'b0; bnd_gen = '0; bnd_line = '0; bnd_next = '0; bnd_data = '0;
        inst_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 reset inst idle", 64'(inst_valid), 64'd0);
        chk("R4 reset fetch idle", 64'(fr_valid), 64'd0);

        for (int i = 0; i < 8; i++) begin
            logic [LA_W-1:0] ln;
            ln = VEC[i].start[PC_W-1:LINE_LOG2];
            do_restart(VEC[i].start, GEN_W'(i + 1));
            put_bundle(exp_up, ln, ln + LA_W'(1), VEC[i].start[5:0], VEC[i].bytes);
            wait_inst();
            bnd_valid = 1'b0;
            chk("R4 emitted", 64'(inst_valid), 64'd1);
            chk("R4 generation tag", 64'(inst_gen), 64'(i + 1));
            chk("R1 opcode field", inst_fields[63:0], VEC[i].opc);
            chk("R4 linear next pc", 64'(inst_lin), 64'(VEC[i].lin));
            chk("R7 prediction valid", 64'(inst_ok), 64'(VEC[i].ok));
            if (VEC[i].ok) chk("R5 R6 predicted pc", 64'(inst_pred), 64'(VEC[i].pred));
            chk("R9 divergence request", 64'(fr_valid), 64'(VEC[i].div));
            if (VEC[i].div) begin
                exp_up++;
                chk("R9 divergence gen", 64'(fr_gen), 64'(exp_up));
                chk("R9 divergence line", 64'(fr_line), 64'(VEC[i].pred[PC_W-1:LINE_LOG2]));
                chk("R9 divergence source", 64'(fr_prev), 64'(ln));
            end
        end

        // R7: stall after an unknown-target jump, pc is 0x42
        put_bundle(exp_up, LA_W'(1), LA_W'(2), 6'd2, 64'h05);
        #1 chk("R7 stalled bundle kept", 64'(bnd_pop), 64'd0);
        @(negedge clk);
        @(negedge clk);
        chk("R7 no emission while stalled", 64'(inst_valid), 64'd0);
        bnd_valid = 1'b0;

        // R2: five-byte instruction needs two cycles
        do_restart(32'h40, 4'd9);
        put_bundle(exp_up, LA_W'(1), LA_W'(2), 6'd0, 64'h0780808080);
        @(negedge clk);
        chk("R2 four bytes only in first cycle", 64'(inst_valid), 64'd0);
        @(negedge clk);
        bnd_valid = 1'b0;
        chk("R2 second cycle emits", 64'(inst_valid), 64'd1);
        chk("R2 opcode", inst_fields[63:0], 64'h7);
        chk("R2 linear pc", 64'(inst_lin), 64'h45);

        // R2/R3/R4: one instruction per cycle, back-pressure, cleared fields
        do_restart(32'h40, 4'd10);
        inst_ready = 1'b0;
        put_bundle(exp_up, LA_W'(1), LA_W'(2), 6'd0, 64'h0605);
        @(negedge clk);
        chk("R2 single instruction per cycle", inst_fields[63:0], 64'h5);
        chk("R2 linear pc first", 64'(inst_lin), 64'h41);
        @(negedge clk);
        chk("R3 held valid", 64'(inst_valid), 64'd1);
        chk("R3 held opcode", inst_fields[63:0], 64'h5);
        chk("R3 held linear pc", 64'(inst_lin), 64'h41);
        inst_ready = 1'b1;
        @(negedge clk);
        bnd_valid = 1'b0;
        chk("R4 next instruction from clear fields", inst_fields[63:0], 64'h6);
        chk("R3 resumed linear pc", 64'(inst_lin), 64'h42);

        // R10: stale generation dropped, pc is 0x42
        put_bundle(exp_up - GEN_W'(1), LA_W'(1), LA_W'(2), 6'd2, 64'h05);
        #1 chk("R10 stale bundle popped", 64'(bnd_pop), 64'd1);
        @(negedge clk);
        chk("R10 stale bundle not decoded", 64'(inst_valid), 64'd0);
        chk("R10 stale bundle no request", 64'(fr_valid), 64'd0);

        // R10: other line equal to pc line via hint: dropped without request
        put_bundle(exp_up, LA_W'(0), LA_W'(1), 6'd2, 64'h05);
        #1 chk("R10 behind line popped", 64'(bnd_pop), 64'd1);
        @(negedge clk);
        chk("R10 hinted line no request", 64'(fr_valid), 64'd0);
        chk("R10 behind line not decoded", 64'(inst_valid), 64'd0);

        // R9: unrelated line triggers fetch restart
        put_bundle(exp_up, LA_W'(5), LA_W'(6), 6'd2, 64'h05);
        #1 chk("R10 unrelated line popped", 64'(bnd_pop), 64'd1);
        @(negedge clk);
        bnd_valid = 1'b0;
        exp_up++;
        chk("R9 request raised", 64'(fr_valid), 64'd1);
        chk("R9 request gen", 64'(fr_gen), 64'(exp_up));
        chk("R9 request line", 64'(fr_line), 64'd1);
        chk("R9 request source", 64'(fr_prev), 64'd5);
        @(negedge clk);
        chk("R9 request is one cycle", 64'(fr_valid), 64'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule